// File: doc/BRIEF.md
# Integer Register File with Debug Taps

This block holds the integer register set of a small processor core: 32 registers of 32 bits each. One write port updates a single register on the rising clock edge when its enable is high. Two independent read ports return register contents combinationally, so the core can fetch both source operands in the same cycle.

Register zero always reads as zero, and writes aimed at it are discarded. Eight frequently inspected registers are also driven continuously onto dedicated observation outputs. A test environment can follow the return address, stack pointer, temporaries, saved registers and first argument register on these outputs without using the read ports.

A synchronous, active-high reset clears the whole file. Forwarding, additional write ports and hazard handling are left to the surrounding pipeline.

Top module: `reg_file_dbg`

## Requirements
- R1: While `rst` is high at a rising edge, every register is cleared. After that edge both read ports and all eight debug outputs show zero.
- R2: With `wr_en` high and `rst` low, `wr_data` is stored at the rising edge into the register numbered by `wr_addr`. From the following cycle either read port returns it when addressed with that number.
- R3: With `wr_en` low, no register changes at the clock edge, whatever `wr_addr` and `wr_data` carry.
- R4: A write changes only the addressed register; all 31 others keep their values.
- R5: Register 0 reads as zero on both ports at all times, and a write with `wr_addr` = 0 has no effect.
- R6: A read of a register in the same cycle that it is being written returns the value held before the edge.
- R7: The two read ports are independent: each returns the register chosen by its own address, in the same cycle, including when both choose the same register.
- R8: The debug outputs continuously show these registers: `dbg_ra` = register 1, `dbg_sp` = register 2, `dbg_t0` = register 5, `dbg_t1` = register 6, `dbg_t2` = register 7, `dbg_s0` = register 8, `dbg_s1` = register 9, `dbg_a0` = register 10.
- R9: Reset wins over a write in the same cycle: with `rst` and `wr_en` both high, the addressed register ends up at zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes and reset act on its rising edge |
| rst | input | 1 | Synchronous active-high clear of all registers |
| wr_en | input | 1 | Write enable for the write port |
| wr_addr | input | 5 | Number of the register to write |
| wr_data | input | 32 | Value to write |
| rd_addr_a | input | 5 | Register number for read port A |
| rd_data_a | output | 32 | Contents of the register chosen by `rd_addr_a` |
| rd_addr_b | input | 5 | Register number for read port B |
| rd_data_b | output | 32 | Contents of the register chosen by `rd_addr_b` |
| dbg_ra | output | 32 | Live copy of register 1 |
| dbg_sp | output | 32 | Live copy of register 2 |
| dbg_t0 | output | 32 | Live copy of register 5 |
| dbg_t1 | output | 32 | Live copy of register 6 |
| dbg_t2 | output | 32 | Live copy of register 7 |
| dbg_s0 | output | 32 | Live copy of register 8 |
| dbg_s1 | output | 32 | Live copy of register 9 |
| dbg_a0 | output | 32 | Live copy of register 10 |

## Verification
A corrupted register shows up on a tapped debug output in the cycle after the faulty edge. For any other register it stays hidden until a read port selects it, so the bench reads every register back on both ports after patterned writes. A decoder that enables the wrong register, or more than one, leaves a stale or overwritten value that the next full sweep exposes. A missing zero clamp on register 0 appears the first time it is read after a write to it. A write that leaks through too early is caught by reading the target during the write cycle itself.

// File: rtl/rf_pkg.sv
package rf_pkg;
    // Number of registers mirrored on debug outputs
    localparam int NUM_TAPS = 8;

    // Register numbers mirrored, in debug output order: ra, sp, t0, t1, t2, s0, s1, a0
    localparam int TAP_IDX [NUM_TAPS] = '{1, 2, 5, 6, 7, 8, 9, 10};

    // Largest tapped index plus one; the file must be at least this deep
    localparam int MIN_REGS = 11;
endpackage

// File: rtl/rf_wr_decode.sv
// Turns the write address and global enable into one-hot per-register enables.
module rf_wr_decode #(
    parameter int NUM_REGS = 32,
    parameter int ADDR_W   = $clog2(NUM_REGS)
) (
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    output logic [NUM_REGS-1:0] reg_we
);
    always_comb begin
        reg_we          = '0;
        reg_we[wr_addr] = wr_en;
        // Register 0 never takes a write
        reg_we[0]       = 1'b0;
    end
endmodule

// File: rtl/rf_storage.sv
// Register array in two-process form: next state computed in one block, flopped in another.
module rf_storage #(
    parameter int NUM_REGS = 32,
    parameter int DATA_W   = 32
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic [NUM_REGS-1:0]              reg_we,
    input  logic [DATA_W-1:0]                wr_data,
    output logic [NUM_REGS-1:0][DATA_W-1:0]  regs
);
    typedef struct packed {
        logic [NUM_REGS-1:0][DATA_W-1:0] file;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (reg_we[i]) begin
                st_d.file[i] = wr_data;
            end
        end
        st_d.file[0] = '0;
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign regs = st_q.file;
endmodule

// File: rtl/rf_read_mux.sv
// One combinational read port: selects a register by number.
module rf_read_mux #(
    parameter int NUM_REGS = 32,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = $clog2(NUM_REGS)
) (
    input  logic [NUM_REGS-1:0][DATA_W-1:0] regs,
    input  logic [ADDR_W-1:0]               rd_addr,
    output logic [DATA_W-1:0]               rd_data
);
    always_comb begin
        rd_data = regs[rd_addr];
    end
endmodule

// File: rtl/reg_file_dbg.sv
module reg_file_dbg #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr_a,
    output logic [DATA_W-1:0] rd_data_a,
    input  logic [ADDR_W-1:0] rd_addr_b,
    output logic [DATA_W-1:0] rd_data_b,
    output logic [DATA_W-1:0] dbg_ra,
    output logic [DATA_W-1:0] dbg_sp,
    output logic [DATA_W-1:0] dbg_t0,
    output logic [DATA_W-1:0] dbg_t1,
    output logic [DATA_W-1:0] dbg_t2,
    output logic [DATA_W-1:0] dbg_s0,
    output logic [DATA_W-1:0] dbg_s1,
    output logic [DATA_W-1:0] dbg_a0
);
    import rf_pkg::*;

    localparam int NUM_REGS = 1 << ADDR_W;

    logic [NUM_REGS-1:0]             reg_we;
    logic [NUM_REGS-1:0][DATA_W-1:0] regs;
    logic [NUM_TAPS-1:0][DATA_W-1:0] taps;
    logic [1:0][ADDR_W-1:0]          rd_addr;
    logic [1:0][DATA_W-1:0]          rd_data;

    rf_wr_decode #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) u_dec (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .reg_we  (reg_we)
    );

    rf_storage #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_store (
        .clk     (clk),
        .rst     (rst),
        .reg_we  (reg_we),
        .wr_data (wr_data),
        .regs    (regs)
    );

    assign rd_addr[0] = rd_addr_a;
    assign rd_addr[1] = rd_addr_b;

    for (genvar p = 0; p < 2; p++) begin : g_rd
        rf_read_mux #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mux (
            .regs    (regs),
            .rd_addr (rd_addr[p]),
            .rd_data (rd_data[p])
        );
    end

    assign rd_data_a = rd_data[0];
    assign rd_data_b = rd_data[1];

    if (NUM_REGS >= MIN_REGS) begin : g_taps
        for (genvar t = 0; t < NUM_TAPS; t++) begin : g_tap
            assign taps[t] = regs[TAP_IDX[t]];
        end
    end else begin : g_no_taps
        assign taps = '0;
    end

    assign dbg_ra = taps[0];
    assign dbg_sp = taps[1];
    assign dbg_t0 = taps[2];
    assign dbg_t1 = taps[3];
    assign dbg_t2 = taps[4];
    assign dbg_s0 = taps[5];
    assign dbg_s1 = taps[6];
    assign dbg_a0 = taps[7];
endmodule

// File: rtl/rf_checker.sv
module rf_checker #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [ADDR_W-1:0] rd_addr_a,
    input logic [DATA_W-1:0] rd_data_a,
    input logic [ADDR_W-1:0] rd_addr_b,
    input logic [DATA_W-1:0] rd_data_b,
    input logic [DATA_W-1:0] dbg_ra,
    input logic [DATA_W-1:0] dbg_sp,
    input logic [DATA_W-1:0] dbg_t0,
    input logic [DATA_W-1:0] dbg_t1,
    input logic [DATA_W-1:0] dbg_t2,
    input logic [DATA_W-1:0] dbg_s0,
    input logic [DATA_W-1:0] dbg_s1,
    input logic [DATA_W-1:0] dbg_a0
);
    logic [8*DATA_W-1:0] dbg_all;
    assign dbg_all = {dbg_ra, dbg_sp, dbg_t0, dbg_t1, dbg_t2, dbg_s0, dbg_s1, dbg_a0};

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        $past(rst) |-> (dbg_all == '0 && rd_data_a == '0 && rd_data_b == '0));

    // R2
    write_visible_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr != '0) |=>
            (rd_addr_a != $past(wr_addr) || rd_data_a == $past(wr_data)));

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(dbg_all));

    // R5
    zero_port_a_chk: assert property (@(posedge clk)
        rd_addr_a == '0 |-> rd_data_a == '0);

    // R5
    zero_port_b_chk: assert property (@(posedge clk)
        rd_addr_b == '0 |-> rd_data_b == '0);

    // R7
    ports_agree_chk: assert property (@(posedge clk)
        rd_addr_a == rd_addr_b |-> rd_data_a == rd_data_b);

    // R8
    tap_ra_chk: assert property (@(posedge clk)
        rd_addr_a == ADDR_W'(1) |-> rd_data_a == dbg_ra);

    // R8
    tap_a0_chk: assert property (@(posedge clk)
        rd_addr_b == ADDR_W'(10) |-> rd_data_b == dbg_a0);
endmodule

bind reg_file_dbg rf_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_addr_a (rd_addr_a),
    .rd_data_a (rd_data_a),
    .rd_addr_b (rd_addr_b),
    .rd_data_b (rd_data_b),
    .dbg_ra    (dbg_ra),
    .dbg_sp    (dbg_sp),
    .dbg_t0    (dbg_t0),
    .dbg_t1    (dbg_t1),
    .dbg_t2    (dbg_t2),
    .dbg_s0    (dbg_s0),
    .dbg_s1    (dbg_s1),
    .dbg_a0    (dbg_a0)
);

// File: tb/tb_reg_file_dbg.sv
`timescale 1ns/1ps
module tb_reg_file_dbg;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [4:0]  rd_addr_a = '0;
    logic [4:0]  rd_addr_b = '0;
    logic [31:0] rd_data_a, rd_data_b;
    logic [31:0] dbg_ra, dbg_sp, dbg_t0, dbg_t1, dbg_t2, dbg_s0, dbg_s1, dbg_a0;

    always #2 clk = ~clk;

    reg_file_dbg dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
        .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b),
        .dbg_ra(dbg_ra), .dbg_sp(dbg_sp), .dbg_t0(dbg_t0), .dbg_t1(dbg_t1),
        .dbg_t2(dbg_t2), .dbg_s0(dbg_s0), .dbg_s1(dbg_s1), .dbg_a0(dbg_a0)
    );

    // Independent reference contents
    logic [31:0] model [32];

    // Scoreboard queues: which output, expected value, requirement tag
    int          q_which [$];
    logic [31:0] q_exp   [$];
    string       q_tag   [$];
    event        sample_ev;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // Debug output order matches R8: registers 1,2,5,6,7,8,9,10
    int tap_reg [8] = '{1, 2, 5, 6, 7, 8, 9, 10};

    function automatic logic [31:0] actual(int which);
        case (which)
            0: return rd_data_a;
            1: return rd_data_b;
            2: return dbg_ra;
            3: return dbg_sp;
            4: return dbg_t0;
            5: return dbg_t1;
            6: return dbg_t2;
            7: return dbg_s0;
            8: return dbg_s1;
            default: return dbg_a0;
        endcase
    endfunction

    // Monitor: pops and compares every pending expectation
    initial begin
        forever begin
            @(sample_ev);
            while (q_which.size() > 0) begin
                int          w;
                logic [31:0] e;
                string       t;
                logic [31:0] a;
                w = q_which.pop_front();
                e = q_exp.pop_front();
                t = q_tag.pop_front();
                a = actual(w);
                n_checks++;
                if (a !== e) begin
                    n_fail++;
                    $display("FAIL %s output %0d: actual %h expected %h", t, w, a, e);
                end
            end
        end
    end

    task automatic push(int which, logic [31:0] exp, string tag);
        q_which.push_back(which);
        q_exp.push_back(exp);
        q_tag.push_back(tag);
    endtask

    task automatic flush();
        -> sample_ev;
        #0.5;
    endtask

    task automatic do_write(logic [4:0] a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (a != 0) model[a] = d;
    endtask

    task automatic read_pair(logic [4:0] a, logic [4:0] b, string tag);
        @(negedge clk);
        rd_addr_a = a; rd_addr_b = b;
        #0.5;
        push(0, model[a], tag);
        push(1, model[b], tag);
        flush();
    endtask

    task automatic check_taps(string tag);
        #0.5;
        for (int k = 0; k < 8; k++) push(2 + k, model[tap_reg[k]], tag);
        flush();
    endtask

    task automatic sweep(string tag);
        for (int r = 0; r < 32; r++) read_pair(5'(r), 5'(31 - r), tag);
    endtask

    initial begin
        #100000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 32; i++) model[i] = '0;
        // R1: reset clears everything
        repeat (2) @(negedge clk);
        rst = 1'b0;
        check_taps("R1");
        sweep("R1");

        // R2, R8: write each register with a pattern and read back
        for (int r = 1; r < 32; r++) do_write(5'(r), 32'hA5000000 ^ (32'(r) * 32'h01010101));
        sweep("R2");
        check_taps("R8");

        // R5: write to register 0 ignored
        do_write(5'd0, 32'hFFFFFFFF);
        read_pair(5'd0, 5'd0, "R5");

        // R3: enable low with busy address/data changes nothing
        @(negedge clk);
        wr_en = 1'b0; wr_addr = 5'd10; wr_data = 32'hDEADBEEF;
        @(negedge clk);
        check_taps("R3");
        read_pair(5'd10, 5'd20, "R3");

        // R4: single write leaves neighbours alone
        do_write(5'd6, 32'h12345678);
        sweep("R4");
        check_taps("R4");

        // R6: same-cycle read returns old value
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 5'd9; wr_data = 32'h0BADF00D;
        rd_addr_a = 5'd9; rd_addr_b = 5'd9;
        #0.5;
        push(0, model[9], "R6");
        push(1, model[9], "R6");
        push(8, model[9], "R6");
        flush();
        @(negedge clk);
        wr_en = 1'b0;
        model[9] = 32'h0BADF00D;
        read_pair(5'd9, 5'd9, "R6");

        // R7: independent ports, mixed addresses
        read_pair(5'd3, 5'd31, "R7");
        read_pair(5'd31, 5'd3, "R7");
        read_pair(5'd17, 5'd17, "R7");

        // R9: reset beats a simultaneous write
        @(negedge clk);
        rst = 1'b1; wr_en = 1'b1; wr_addr = 5'd7; wr_data = 32'h77777777;
        @(negedge clk);
        rst = 1'b0; wr_en = 1'b0;
        for (int i = 0; i < 32; i++) model[i] = '0;
        read_pair(5'd7, 5'd2, "R9");
        check_taps("R9");
        sweep("R1");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule